// File: doc/BRIEF.md
# Matrix Keyboard Scan Controller

This block scans a key matrix of up to 16 rows and 8 columns. It pulls one row low at a time and reads the column lines. A key is recorded only if its column stays low for a whole debounce window. After each full pass over the rows, it publishes a snapshot of up to eight pressed keys. Each key is one byte that holds a valid mark, the row number and the column number. Software reads the snapshot as two packed 32-bit words. Beside them sit a control word, a status word with the entry count and two sticky flags, and one mask word per row.

All scan timing counts pulses of the `scan_tick` enable, which comes from a slow scan clock made outside the block. The scan sequencer has four states:
- `SC_OFF`: rows released.
- `SC_LEAD`: the pause before the first row.
- `SC_ROW`: one row driven.
- `SC_PUBLISH`: a one-cycle snapshot hand-over.

It has these transitions:
- Off to Lead, when scanning is enabled.
- Lead to Row, on the fifth tick.
- Row to Row, at the end of a row window when the row is not the last one.
- Row to Publish, at the end of the last row.
- Publish to Lead, unconditionally.
- Any state to Off, when scanning is disabled.

The `irq` line is high whenever a set status flag has its interrupt enabled.

Top module: `kbd_matrix_scan`

## Requirements
- R1: Each entry is one byte: bit 7 marks it valid, bits 6:3 hold the row and bits 2:0 hold the column. Entries 0..3 are read at word address 2 and entries 4..7 at word address 3, with the lower-numbered entry in the less significant byte. Invalid entries read as zero.
- R2: Entries are filled in row-then-column order, lowest first. At most eight are kept. The status word (address 1) gives the number of valid entries in bits 7:4.
- R3: Rows are active low, with at most one row low at a time. A row stays driven for 16 plus the debounce count ticks. Between the last row and row 0, all rows stay high for 6 cycles (one publish cycle and 5 lead ticks). Control is word address 0. Bit 0 enables scanning, bit 1 enables the keypress interrupt, bit 3 enables the count interrupt, bits 13:4 hold the debounce count and bits 17:14 hold the count threshold. Control reads back as written.
- R4: A key is recorded only if its column reads low on each of the last (debounce count + 1) ticks of its row window. A high reading earlier in the window does not stop the key from being recorded.
- R5: Status bit 2 is set after a snapshot is published whose entry count is at least a nonzero threshold. A threshold of 0 never sets it.
- R6: Status bit 0 is set when a recorded key is not masked. The mask word for row r sits at word address 8+r, and its bit c blocks column c. All ones blocks the whole row. Masked keys are still recorded.
- R7: Writing 1 to status bit 0 or bit 2 clears that flag. Writing 0 leaves the flag unchanged.
- R8: `irq` equals (bit 0 AND keypress enable) OR (bit 2 AND count enable).
- R9: When the enable bit is 0, all rows stay high, the entry count reads 0 and both entry words read 0.
- R10: After reset, control, status, entries and masks read 0, all rows are high and `irq` is low.
- R11: While `scan_tick` is low, the driven row does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| scan_tick | input | 1 | one-cycle enable per slow scan-clock period |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| row_n | output | NUM_ROWS | row drive, active low |
| col_in | input | NUM_COLS | column sense, low means connected |
| irq | output | 1 | interrupt request |

## Verification
The bench builds the block with NUM_ROWS = 4 and NUM_COLS = 8, and keeps `scan_tick` high. With debounce count 0, a full pass then takes 70 cycles. This makes it cheap to sweep every single key of the 32-key matrix and a family of multi-key patterns, including the fully pressed matrix that tests the eight-entry cap. With a debounce count of 20, glitches can be placed cycle by cycle inside or before the sampling window of a chosen row.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    typedef enum logic [1:0] {
        SC_OFF,
        SC_LEAD,
        SC_ROW,
        SC_PUBLISH
    } scan_state_e;

    localparam int ROW_FIELD_W = 4;
    localparam int COL_FIELD_W = 3;
    localparam int ENTRY_W     = 8;

    // Register word addresses
    localparam int ADR_CTRL      = 0;
    localparam int ADR_STAT      = 1;
    localparam int ADR_ENT_LO    = 2;
    localparam int ADR_ENT_HI    = 3;
    localparam int ADR_MASK_BASE = 8;

    function automatic logic [ENTRY_W-1:0] make_entry(
        input logic [ROW_FIELD_W-1:0] r,
        input logic [COL_FIELD_W-1:0] c
    );
        return {1'b1, r, c};
    endfunction

endpackage

// File: rtl/kbd_scan_fsm.sv
module kbd_scan_fsm
    import kbd_scan_pkg::*;
#(
    parameter int NUM_ROWS   = 16,
    parameter int NUM_COLS   = 8,
    parameter int ROW_BASE   = 16,
    parameter int LEAD_TICKS = 5,
    parameter int DEB_W      = 10,
    localparam int ROW_IDX_W = $clog2(NUM_ROWS),
    localparam int CNT_W     = DEB_W + $clog2(ROW_BASE + LEAD_TICKS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 scan_tick,
    input  logic [DEB_W-1:0]     deb_cnt,
    input  logic [NUM_COLS-1:0]  col_in,
    output logic [NUM_ROWS-1:0]  row_n,
    output logic                 row_done,
    output logic [ROW_IDX_W-1:0] done_row,
    output logic [NUM_COLS-1:0]  row_hits,
    output logic                 pass_done
);

    localparam logic [ROW_IDX_W-1:0] LAST_ROW  = ROW_IDX_W'(NUM_ROWS - 1);
    localparam logic [CNT_W-1:0]     LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
    localparam logic [CNT_W-1:0]     WIN_OPEN  = CNT_W'(ROW_BASE - 1);

    scan_state_e          state, nxt_state;
    logic [CNT_W-1:0]     tick_cnt;
    logic [ROW_IDX_W-1:0] row_idx;
    logic [NUM_COLS-1:0]  low_acc;
    logic [CNT_W-1:0]     win_last;
    logic                 win_end;
    logic                 lead_end;

    assign win_last = CNT_W'(ROW_BASE) + CNT_W'(deb_cnt) - CNT_W'(1);
    assign win_end  = scan_tick && (tick_cnt == win_last);
    assign lead_end = scan_tick && (tick_cnt == LEAD_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_OFF;
        else        state <= nxt_state;
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            SC_OFF:     if (enable) nxt_state = SC_LEAD;
            SC_LEAD:    if (lead_end) nxt_state = SC_ROW;
            SC_ROW:     if (win_end && row_idx == LAST_ROW) nxt_state = SC_PUBLISH;
            SC_PUBLISH: nxt_state = SC_LEAD;
            default:    nxt_state = SC_OFF;
        endcase
        if (!enable) nxt_state = SC_OFF;
    end

    // Tick counter, row index and debounce accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            row_idx  <= '0;
            low_acc  <= '1;
        end else if (!enable) begin
            tick_cnt <= '0;
            row_idx  <= '0;
            low_acc  <= '1;
        end else begin
            unique case (state)
                SC_LEAD: begin
                    if (lead_end) begin
                        tick_cnt <= '0;
                        row_idx  <= '0;
                        low_acc  <= '1;
                    end else if (scan_tick) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
                SC_ROW: begin
                    if (win_end) begin
                        tick_cnt <= '0;
                        low_acc  <= '1;
                        if (row_idx != LAST_ROW) row_idx <= row_idx + ROW_IDX_W'(1);
                    end else if (scan_tick) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                        if (tick_cnt >= WIN_OPEN) low_acc <= low_acc & ~col_in;
                    end
                end
                default: begin
                    tick_cnt <= '0;
                    row_idx  <= '0;
                    low_acc  <= '1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        row_n     = '1;
        row_done  = 1'b0;
        pass_done = 1'b0;
        done_row  = row_idx;
        row_hits  = low_acc & ~col_in;
        unique case (state)
            SC_ROW: begin
                row_n[row_idx] = 1'b0;
                row_done       = enable && win_end;
            end
            SC_PUBLISH: pass_done = enable;
            default: ;
        endcase
    end

    p_single_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n) <= 1);

    p_idle_rows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (row_n == '1));

    p_row_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !scan_tick && state == SC_ROW) |=> $stable(row_n));

endmodule

// File: rtl/kbd_entry_collect.sv
module kbd_entry_collect
    import kbd_scan_pkg::*;
#(
    parameter int NUM_COLS  = 8,
    parameter int MAX_ENT   = 8,
    parameter int ROW_IDX_W = 4,
    localparam int N_W      = $clog2(MAX_ENT + 1),
    localparam int IDX_W    = $clog2(MAX_ENT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         row_done,
    input  logic [ROW_IDX_W-1:0]         done_row,
    input  logic [NUM_COLS-1:0]          row_hits,
    input  logic                         pass_done,
    output logic [MAX_ENT*ENTRY_W-1:0]   ent_flat,
    output logic [N_W-1:0]               ent_count
);

    logic [ENTRY_W-1:0] work [MAX_ENT];
    logic [ENTRY_W-1:0] nxt_work [MAX_ENT];
    logic [ENTRY_W-1:0] pub [MAX_ENT];
    logic [N_W-1:0]     work_n, nxt_n;
    logic [MAX_ENT-1:0] valid_bits;

    // Append this row's hits in column order, up to the cap
    always_comb begin
        nxt_work = work;
        nxt_n    = work_n;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (row_hits[c] && nxt_n < N_W'(MAX_ENT)) begin
                nxt_work[nxt_n[IDX_W-1:0]] = make_entry(ROW_FIELD_W'(done_row), COL_FIELD_W'(c));
                nxt_n = nxt_n + N_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_n    <= '0;
            ent_count <= '0;
            for (int i = 0; i < MAX_ENT; i++) begin
                work[i] <= '0;
                pub[i]  <= '0;
            end
        end else if (!enable) begin
            work_n    <= '0;
            ent_count <= '0;
            for (int i = 0; i < MAX_ENT; i++) begin
                work[i] <= '0;
                pub[i]  <= '0;
            end
        end else if (row_done) begin
            work   <= nxt_work;
            work_n <= nxt_n;
        end else if (pass_done) begin
            pub       <= work;
            ent_count <= work_n;
            work_n    <= '0;
            for (int i = 0; i < MAX_ENT; i++) work[i] <= '0;
        end
    end

    generate
        for (genvar g = 0; g < MAX_ENT; g++) begin : g_flat
            assign ent_flat[g*ENTRY_W +: ENTRY_W] = pub[g];
            assign valid_bits[g] = pub[g][ENTRY_W-1];
        end
    endgenerate

    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ent_count <= N_W'(MAX_ENT));

    p_valid_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_bits) == int'(ent_count));

    p_clear_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ent_count == '0 && ent_flat == '0));

endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_scan_pkg::*;
#(
    parameter int NUM_ROWS  = 16,
    parameter int NUM_COLS  = 8,
    parameter int ADDR_W    = 5,
    parameter int DEB_W     = 10,
    parameter int THR_W     = 4,
    parameter int MAX_ENT   = 8,
    localparam int ROW_IDX_W = $clog2(NUM_ROWS),
    localparam int N_W       = $clog2(MAX_ENT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic                       row_done,
    input  logic [ROW_IDX_W-1:0]       done_row,
    input  logic [NUM_COLS-1:0]        row_hits,
    input  logic                       pass_done,
    input  logic [MAX_ENT*ENTRY_W-1:0] ent_flat,
    input  logic [N_W-1:0]             ent_count,
    output logic                       enable,
    output logic [DEB_W-1:0]           deb_cnt,
    output logic                       irq
);

    localparam int DEB_LSB = 4;
    localparam int THR_LSB = 14;

    logic [31:0]         ctl_q;
    logic [NUM_COLS-1:0] mask_q [NUM_ROWS];
    logic                kp_flag, th_flag;
    logic                kp_set, th_set;
    logic                pub_seen;
    logic                kp_ie, th_ie;
    logic [THR_W-1:0]    thr;
    logic                stat_wr;

    assign enable  = ctl_q[0];
    assign kp_ie   = ctl_q[1];
    assign th_ie   = ctl_q[3];
    assign deb_cnt = ctl_q[DEB_LSB +: DEB_W];
    assign thr     = ctl_q[THR_LSB +: THR_W];
    assign stat_wr = reg_we && (reg_addr == ADDR_W'(ADR_STAT));

    assign kp_set = row_done && |(row_hits & ~mask_q[done_row]);
    assign th_set = pub_seen && (thr != '0) && (THR_W'(ent_count) >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            kp_flag  <= 1'b0;
            th_flag  <= 1'b0;
            pub_seen <= 1'b0;
        end else begin
            pub_seen <= pass_done;
            if (reg_we && reg_addr == ADDR_W'(ADR_CTRL)) ctl_q <= reg_wdata;
            kp_flag <= kp_set | (kp_flag & ~(stat_wr & reg_wdata[0]));
            th_flag <= th_set | (th_flag & ~(stat_wr & reg_wdata[2]));
        end
    end

    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_mask
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mask_q[r] <= '0;
                else if (reg_we && reg_addr == ADDR_W'(ADR_MASK_BASE + r))
                    mask_q[r] <= reg_wdata[NUM_COLS-1:0];
            end
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_CTRL))        reg_rdata = ctl_q;
        else if (reg_addr == ADDR_W'(ADR_STAT))   reg_rdata = {24'b0, 4'(ent_count), 1'b0, th_flag, 1'b0, kp_flag};
        else if (reg_addr == ADDR_W'(ADR_ENT_LO)) reg_rdata = ent_flat[31:0];
        else if (reg_addr == ADDR_W'(ADR_ENT_HI)) reg_rdata = ent_flat[63:32];
        else begin
            for (int r = 0; r < NUM_ROWS; r++)
                if (reg_addr == ADDR_W'(ADR_MASK_BASE + r)) reg_rdata = 32'(mask_q[r]);
        end
    end

    assign irq = (kp_flag & kp_ie) | (th_flag & th_ie);

    p_w1c_kp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[0] && !kp_set) |=> !kp_flag);

    p_w1c_th_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[2] && !th_set) |=> !th_flag);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!kp_ie && !th_ie) |-> !irq);

    p_no_thr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0 && !th_flag && !(reg_we && reg_addr == ADDR_W'(ADR_CTRL))) |=> !th_flag);

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
    import kbd_scan_pkg::*;
#(
    parameter int NUM_ROWS   = 16,
    parameter int NUM_COLS   = 8,
    parameter int ADDR_W     = 5,
    parameter int ROW_BASE   = 16,
    parameter int LEAD_TICKS = 5,
    parameter int DEB_W      = 10,
    parameter int THR_W      = 4,
    parameter int MAX_ENT    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_tick,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_ROWS-1:0] row_n,
    input  logic [NUM_COLS-1:0] col_in,
    output logic                irq
);

    localparam int ROW_IDX_W = $clog2(NUM_ROWS);
    localparam int N_W       = $clog2(MAX_ENT + 1);

    logic                       enable;
    logic [DEB_W-1:0]           deb_cnt;
    logic                       row_done, pass_done;
    logic [ROW_IDX_W-1:0]       done_row;
    logic [NUM_COLS-1:0]        row_hits;
    logic [MAX_ENT*ENTRY_W-1:0] ent_flat;
    logic [N_W-1:0]             ent_count;

    kbd_scan_fsm #(
        .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_BASE(ROW_BASE),
        .LEAD_TICKS(LEAD_TICKS), .DEB_W(DEB_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scan_tick(scan_tick),
        .deb_cnt(deb_cnt), .col_in(col_in), .row_n(row_n),
        .row_done(row_done), .done_row(done_row), .row_hits(row_hits),
        .pass_done(pass_done)
    );

    kbd_entry_collect #(
        .NUM_COLS(NUM_COLS), .MAX_ENT(MAX_ENT), .ROW_IDX_W(ROW_IDX_W)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .enable(enable), .row_done(row_done),
        .done_row(done_row), .row_hits(row_hits), .pass_done(pass_done),
        .ent_flat(ent_flat), .ent_count(ent_count)
    );

    kbd_regs #(
        .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ADDR_W(ADDR_W),
        .DEB_W(DEB_W), .THR_W(THR_W), .MAX_ENT(MAX_ENT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .row_done(row_done),
        .done_row(done_row), .row_hits(row_hits), .pass_done(pass_done),
        .ent_flat(ent_flat), .ent_count(ent_count), .enable(enable),
        .deb_cnt(deb_cnt), .irq(irq)
    );

endmodule

// File: tb/kbd_matrix_scan_test.sv
module kbd_matrix_scan_test;

    localparam int NR = 4;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_tick = 1'b1;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NR-1:0] row_n;
    logic [NC-1:0] col_in;
    logic          irq;

    logic [NR*NC-1:0] keys = '0;
    logic             glitch = 1'b0;
    int               nchk = 0, nfail = 0;
    bit               done = 0;
    int               cur_deb = 0;

    always #5 clk = ~clk;

    kbd_matrix_scan #(.NUM_ROWS(NR), .NUM_COLS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .row_n(row_n), .col_in(col_in), .irq(irq)
    );

    // Key matrix model: a pressed key ties its column to its driven row
    always_comb begin
        col_in = '1;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                if (keys[r*NC+c] && !row_n[r]) col_in[c] = 1'b0;
        if (glitch) col_in = '1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        cur_deb = int'(v[13:4]);
        wr(0, v);
    endtask

    task automatic wait_passes();
        repeat (2 * (6 + NR * (16 + cur_deb)) + 8) @(negedge clk);
    endtask

    task automatic wait_row(input int idx);
        int g = 0;
        while (row_n != ~(NR'(1) << idx) && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    function automatic void exp_ent(input logic [NR*NC-1:0] k,
                                    output logic [63:0] flat, output int n);
        flat = '0;
        n = 0;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                if (k[r*NC+c] && n < 8) begin
                    flat[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
                    n++;
                end
    endfunction

    task automatic check_snapshot(input string tag);
        logic [63:0] ef;
        int en;
        logic [31:0] lo, hi, st;
        exp_ent(keys, ef, en);
        rd(2, lo); rd(3, hi); rd(1, st);
        chk({tag, " lo"}, lo, ef[31:0]);
        chk({tag, " hi"}, hi, ef[63:32]);
        chk({tag, " count"}, {28'b0, st[7:4]}, 32'(en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R10 watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        logic [NR-1:0] held;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(0, v); chk("R10 ctrl", v, 0);
        rd(1, v); chk("R10 status", v, 0);
        rd(2, v); chk("R10 ent lo", v, 0);
        rd(3, v); chk("R10 ent hi", v, 0);
        rd(8, v); chk("R10 mask0", v, 0);
        chk("R10 rows", 32'(row_n), 32'hF);
        chk("R10 irq", 32'(irq), 0);

        // R3: control readback and row timing, debounce 0, threshold 1
        set_ctrl(32'h1 | (32'd1 << 14));
        rd(0, v); chk("R3 ctrl readback", v, 32'h4001);
        wait_row(3); wait_row(0);
        n = 0;
        while (row_n == 4'b1110 && n < 100) begin @(negedge clk); n++; end
        chk("R3 row window deb0", 32'(n), 16);
        chk("R3 next row", 32'(row_n), 32'hD);
        wait_row(3);
        while (row_n != 4'hF) @(negedge clk);
        n = 0;
        while (row_n == 4'hF && n < 100) begin @(negedge clk); n++; end
        chk("R3 gap between passes", 32'(n), 6);

        // R1: sweep of every single key
        for (int k = 0; k < NR * NC; k++) begin
            keys = '0;
            keys[k] = 1'b1;
            wait_passes();
            check_snapshot("R1 single key");
        end

        // R2: multi-key patterns, including the cap at eight
        for (int p = 0; p < 24; p++) begin
            keys = 32'(p * 32'h9E3779B1) ^ 32'(p * 32'h00010203);
            if (p == 0) keys = '1;
            wait_passes();
            check_snapshot("R2 multi key");
        end

        // R3: window with debounce 3
        set_ctrl(32'h1 | (32'd3 << 4));
        keys = '0;
        wait_row(3); wait_row(0);
        n = 0;
        while (row_n == 4'b1110 && n < 100) begin @(negedge clk); n++; end
        chk("R3 row window deb3", 32'(n), 19);

        // R5: threshold 3 versus entry count
        set_ctrl(32'h1 | (32'd3 << 14));
        keys = 32'h0000_0101;
        wait_passes(); wr(1, 32'h5); wait_passes();
        rd(1, v); chk("R5 two keys below thr", 32'(v[2]), 0);
        keys = 32'h0001_0101;
        wait_passes(); wr(1, 32'h5); wait_passes();
        rd(1, v); chk("R5 three keys at thr", 32'(v[2]), 1);

        // R7: write-one-to-clear, per bit
        keys = '0;
        wait_passes();
        rd(1, v); chk("R7 both flags held", v, 32'h5);
        wr(1, 32'h0); rd(1, v); chk("R7 zero write keeps", v, 32'h5);
        wr(1, 32'h4); rd(1, v); chk("R7 clear th only", v, 32'h1);
        wr(1, 32'h1); rd(1, v); chk("R7 clear kp", v, 32'h0);

        // R8 / R5: interrupt gating, threshold 0 never flags
        set_ctrl(32'h9);
        keys = 32'h1;
        wait_passes();
        rd(1, v);
        chk("R5 thr zero no flag", 32'(v[2]), 0);
        chk("R8 kp flag set", 32'(v[0]), 1);
        chk("R8 irq masked", 32'(irq), 0);
        set_ctrl(32'hB);
        chk("R8 irq kp enabled", 32'(irq), 1);
        keys = '0; wait_passes(); wr(1, 32'h5);
        chk("R8 irq after clear", 32'(irq), 0);
        set_ctrl(32'h9 | (32'd1 << 14));
        keys = 32'h1; wait_passes();
        chk("R8 irq from threshold", 32'(irq), 1);

        // R6: row mask
        set_ctrl(32'h1);
        keys = '0; wait_passes(); wr(1, 32'h5);
        wr(9, 32'hFF);
        rd(9, v); chk("R6 mask readback", v, 32'hFF);
        keys = 32'h1 << 11;
        wait_passes();
        rd(1, v);
        chk("R6 masked row no kp", 32'(v[0]), 0);
        chk("R6 masked key recorded", 32'(v[7:4]), 1);
        keys = keys | 32'h4;
        wait_passes();
        rd(1, v); chk("R6 unmasked row kp", 32'(v[0]), 1);
        wr(9, 32'h0);

        // R4: debounce with count 20
        set_ctrl(32'h1 | (32'd20 << 4));
        keys = 32'h1 << 21;
        wait_passes();
        rd(1, v); chk("R4 steady key", 32'(v[7:4]), 1);
        wait_row(1); wait_row(2);
        repeat (25) @(negedge clk);
        glitch = 1'b1; @(negedge clk); glitch = 1'b0;
        wait_row(3);
        repeat (20 + 16 + 3) @(negedge clk);
        rd(1, v); chk("R4 glitch in window drops", 32'(v[7:4]), 0);
        wait_row(1); wait_row(2);
        repeat (5) @(negedge clk);
        glitch = 1'b1; @(negedge clk); glitch = 1'b0;
        wait_row(3);
        repeat (20 + 16 + 3) @(negedge clk);
        rd(1, v); chk("R4 glitch before window kept", 32'(v[7:4]), 1);

        // R11: no tick, no row advance
        wait_row(1);
        scan_tick = 1'b0;
        held = row_n;
        repeat (60) @(negedge clk);
        chk("R11 row held", 32'(row_n), 32'(held));
        scan_tick = 1'b1;
        n = 0;
        while (row_n == held && n < 100) begin @(negedge clk); n++; end
        chk("R11 resumes", 32'(row_n), 32'hB);

        // R9: disable clears and releases rows
        set_ctrl(32'h0);
        @(negedge clk);
        rd(1, v); chk("R9 count zero", 32'(v[7:4]), 0);
        rd(2, v); chk("R9 entries zero", v, 0);
        repeat (100) @(negedge clk);
        chk("R9 rows released", 32'(row_n), 32'hF);
        rd(3, v); chk("R9 hi zero", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule